// File: doc/BRIEF.md
# Column-Serial AES Block Encryptor

This block encrypts one 128-bit block with AES. It works on a single 32-bit column per clock. A host starts a block and then streams in four pairs of plaintext and key words. Each pair is XORed and shifted into a sixteen-byte state array, which performs the initial key addition. After that the block runs 10, 12 or 14 rounds of four cycles each. In every round cycle one column passes through four substitution boxes and a combinational column mixer. The result is XORed with one round-key word taken from an external key scheduler. The final round skips the column mixer.

ShiftRows has no logic of its own. During a round the four row registers rotate, and each row is read at a stage equal to its row index, so the column that reaches the substitution boxes is already in permuted order. The first three results of a round wait in a three-word holding register. On the fourth cycle the state is reloaded from those three words together with the column computed in that cycle. The ciphertext then leaves the block as four 32-bit words, and a pulse marks the last of them.

Top module: `aes_ws_core`

## Requirements
- R1: While reset is asserted and after it is released, `busy_o`, `ct_valid_o` and `done_o` are low and `ct_word_o` is zero until a block is started.
- R2: In the load phase a word pair is taken only on cycles with `ld_valid_i` high. Exactly four pairs are taken, in block order: word 0 is plaintext bytes 0..3, and byte 0 sits in bits 31:24. On cycles with `ld_valid_i` low the word inputs have no effect on the result or on the timing.
- R3: `key_size_i` is sampled only on the cycle that accepts `start_i`. The encoding is 2'b00 for 10 rounds (128-bit key), 2'b01 for 12 rounds (192-bit key), and 2'b10 or 2'b11 for 14 rounds (256-bit key). Changes to `key_size_i` during a block have no effect.
- R4: The round phase starts on the edge that takes the fourth load pair and lasts 4·Nr cycles. In round i (1..Nr), slot c (0..3), the block samples `rk_word_i` as key-schedule word 4i+c. Without load gaps a block takes 44, 52 or 60 cycles from the first load cycle to the last round cycle.
- R5: The ciphertext equals standard AES encryption of the loaded plaintext under the loaded key for all three key sizes, with the column mixer left out of the final round.
- R6: `ct_valid_o` is high for exactly four consecutive cycles, starting in the cycle after the last round cycle. It presents ciphertext words 0..3 in order, in the same byte order as R2. `done_o` is high only together with word 3.
- R7: `busy_o` rises in the cycle after `start_i` is accepted and falls in the cycle after `done_o`. A new start is accepted from that first idle cycle onward.
- R8: `start_i` asserted while `busy_o` is high is ignored. The running block's timing and result are unchanged.
- R9: `ct_word_o` is zero whenever `ct_valid_o` is low, and the state registers do not change while the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a new block when idle |
| key_size_i | input | 2 | Key length select, sampled with start |
| ld_valid_i | input | 1 | Load pair valid during load phase |
| ld_text_i | input | 32 | Plaintext word |
| ld_key_i | input | 32 | Initial key word |
| rk_word_i | input | 32 | Round-key word for the current round slot |
| busy_o | output | 1 | Block in progress |
| ct_valid_o | output | 1 | Ciphertext word valid |
| done_o | output | 1 | Last ciphertext word of the block |
| ct_word_o | output | 32 | Ciphertext word |

## Verification
The bench aims at the diagonal tap and the round-end reload. A wrong row offset or a misordered reload gives ciphertext that differs from the standard vectors even though the timing stays correct. It breaks up the load phase with gaps that carry garbage data, and it changes `start_i` and `key_size_i` mid-block. A design that took unqualified words, restarted, or re-sampled the key size would shift every later round-key sample and corrupt the result. It also runs the 2'b11 key-size code and two blocks back to back, so an off-by-one in the round count or in the drain length shows up as a misplaced `done_o` or a stretched `busy_o`.

// File: rtl/aes_ws_pkg.sv
package aes_ws_pkg;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ROWS     = 4;
  localparam int unsigned WORD_W   = BYTE_W * ROWS;
  localparam int unsigned STEP_W   = $clog2(ROWS);
  localparam int unsigned NR_BASE  = 10;
  localparam int unsigned NR_STEP  = 2;
  localparam int unsigned RND_W    = $clog2(NR_BASE + 2 * NR_STEP + 1);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {PH_IDLE, PH_LOAD, PH_ROUND, PH_DRAIN} phase_e;
  typedef enum logic [1:0] {SM_HOLD, SM_PUSH, SM_ROTATE, SM_RELOAD} st_mode_e;

  function automatic byte_t xtime(byte_t a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic byte_t gf_mul(byte_t a, byte_t b);
    byte_t acc;
    byte_t aa;
    acc = '0;
    aa  = a;
    for (int i = 0; i < BYTE_W; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = xtime(aa);
    end
    return acc;
  endfunction

  // a^254 by repeated squaring: product of a^2, a^4, ... a^128
  function automatic byte_t gf_inv(byte_t a);
    byte_t p;
    byte_t r;
    p = a;
    r = 8'h01;
    for (int i = 1; i < BYTE_W; i++) begin
      p = gf_mul(p, p);
      r = gf_mul(r, p);
    end
    return r;
  endfunction

  function automatic byte_t sub_byte(byte_t a);
    byte_t v;
    v = gf_inv(a);
    return v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^
           {v[3:0], v[7:4]} ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_ws_sbox.sv
module aes_ws_sbox
  import aes_ws_pkg::*;
(
  input  byte_t in_i,
  output byte_t out_o
);

  assign out_o = sub_byte(in_i);

endmodule

// File: rtl/aes_ws_mixcol.sv
module aes_ws_mixcol
  import aes_ws_pkg::*;
(
  input  word_t col_i,
  input  logic  bypass_i,
  output word_t col_o
);

  byte_t a [ROWS];
  byte_t m [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_split
    assign a[r] = col_i[WORD_W-1-BYTE_W*r -: BYTE_W];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_mix
    assign m[r] = xtime(a[r]) ^ xtime(a[(r+1)%ROWS]) ^ a[(r+1)%ROWS] ^
                  a[(r+2)%ROWS] ^ a[(r+3)%ROWS];
    assign col_o[WORD_W-1-BYTE_W*r -: BYTE_W] = bypass_i ? a[r] : m[r];
  end

endmodule

// File: rtl/aes_ws_state.sv
module aes_ws_state
  import aes_ws_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  st_mode_e mode_i,
  input  logic     out_en_i,
  input  logic     last_rnd_i,
  input  word_t    ld_word_i,
  input  word_t    rk_word_i,
  output word_t    head_o
);

  logic [ROWS-1:0][WORD_W-1:0] col_q, col_d;
  logic [ROWS-2:0][WORD_W-1:0] out_q, out_d;
  word_t tap, sub, mixed, res;
  logic  st_en;

  // diagonal read: row r taken from stage r
  for (genvar r = 0; r < ROWS; r++) begin : g_tap
    assign tap[WORD_W-1-BYTE_W*r -: BYTE_W] = col_q[r][WORD_W-1-BYTE_W*r -: BYTE_W];
    aes_ws_sbox u_sbox (
      .in_i  (tap[WORD_W-1-BYTE_W*r -: BYTE_W]),
      .out_o (sub[WORD_W-1-BYTE_W*r -: BYTE_W])
    );
  end

  aes_ws_mixcol u_mix (
    .col_i    (sub),
    .bypass_i (last_rnd_i),
    .col_o    (mixed)
  );

  assign res    = mixed ^ rk_word_i;
  assign head_o = col_q[0];
  assign st_en  = (mode_i != SM_HOLD);

  always_comb begin
    col_d = col_q;
    case (mode_i)
      SM_PUSH: begin
        for (int j = 0; j < ROWS - 1; j++) col_d[j] = col_q[j+1];
        col_d[ROWS-1] = ld_word_i;
      end
      SM_ROTATE: begin
        for (int j = 0; j < ROWS - 1; j++) col_d[j] = col_q[j+1];
        col_d[ROWS-1] = col_q[0];
      end
      SM_RELOAD: begin
        for (int j = 0; j < ROWS - 1; j++) col_d[j] = out_q[j];
        col_d[ROWS-1] = res;
      end
      default: ;
    endcase
  end

  always_comb begin
    out_d = out_q;
    for (int j = 0; j < ROWS - 2; j++) out_d[j] = out_q[j+1];
    out_d[ROWS-2] = res;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
    end else if (st_en) begin
      col_q <= col_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
    end else if (out_en_i) begin
      out_q <= out_d;
    end
  end

  // R9
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_HOLD) |=> $stable(col_q));

  // R4
  hold_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_PUSH) |=> $stable(out_q));

endmodule

// File: rtl/aes_ws_ctrl.sv
module aes_ws_ctrl
  import aes_ws_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [1:0] key_size_i,
  input  logic       ld_valid_i,
  output st_mode_e   mode_o,
  output logic       out_en_o,
  output logic       last_rnd_o,
  output logic       busy_o,
  output logic       ct_valid_o,
  output logic       done_o
);

  localparam logic [STEP_W-1:0] STEP_LAST = STEP_W'(ROWS - 1);

  phase_e             phase_q, phase_d;
  logic [STEP_W-1:0]  step_q, step_d;
  logic [RND_W-1:0]   rnd_q, rnd_d;
  logic [RND_W-1:0]   nr_q, nr_d, nr_sel;

  always_comb begin
    case (key_size_i)
      2'b00:   nr_sel = RND_W'(NR_BASE);
      2'b01:   nr_sel = RND_W'(NR_BASE + NR_STEP);
      default: nr_sel = RND_W'(NR_BASE + 2 * NR_STEP);
    endcase
  end

  always_comb begin
    phase_d  = phase_q;
    step_d   = step_q;
    rnd_d    = rnd_q;
    nr_d     = nr_q;
    mode_o   = SM_HOLD;
    out_en_o = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_LOAD;
          step_d  = '0;
          rnd_d   = RND_W'(1);
          nr_d    = nr_sel;
        end
      end
      PH_LOAD: begin
        if (ld_valid_i) begin
          mode_o = SM_PUSH;
          step_d = step_q + 1'b1;
          if (step_q == STEP_LAST) phase_d = PH_ROUND;
        end
      end
      PH_ROUND: begin
        step_d = step_q + 1'b1;
        if (step_q == STEP_LAST) begin
          mode_o = SM_RELOAD;
          if (rnd_q == nr_q) phase_d = PH_DRAIN;
          else               rnd_d   = rnd_q + 1'b1;
        end else begin
          mode_o   = SM_ROTATE;
          out_en_o = 1'b1;
        end
      end
      PH_DRAIN: begin
        mode_o = SM_ROTATE;
        step_d = step_q + 1'b1;
        if (step_q == STEP_LAST) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      step_q  <= '0;
      rnd_q   <= '0;
      nr_q    <= '0;
    end else begin
      phase_q <= phase_d;
      step_q  <= step_d;
      rnd_q   <= rnd_d;
      nr_q    <= nr_d;
    end
  end

  assign last_rnd_o = (phase_q == PH_ROUND) && (rnd_q == nr_q);
  assign busy_o     = (phase_q != PH_IDLE);
  assign ct_valid_o = (phase_q == PH_DRAIN);
  assign done_o     = ct_valid_o && (step_q == STEP_LAST);

  // R2
  ld_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_LOAD && !ld_valid_i) |=> (phase_q == PH_LOAD && $stable(step_q)));

  // R3
  rnd_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_ROUND) |-> (rnd_q != '0 && rnd_q <= nr_q));

  // R8
  nr_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(nr_q));

  // R6
  done_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ct_valid_o);

  // R6
  valid_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ct_valid_o) |-> $past(done_o));

  // R7
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);

endmodule

// File: rtl/aes_ws_core.sv
module aes_ws_core
  import aes_ws_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic [1:0]  key_size_i,
  input  logic        ld_valid_i,
  input  logic [31:0] ld_text_i,
  input  logic [31:0] ld_key_i,
  input  logic [31:0] rk_word_i,
  output logic        busy_o,
  output logic        ct_valid_o,
  output logic        done_o,
  output logic [31:0] ct_word_o
);

  logic [1:0] rst_sync_q;
  logic       rst_n;
  st_mode_e   mode;
  logic       out_en, last_rnd;
  word_t      head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  aes_ws_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .start_i    (start_i),
    .key_size_i (key_size_i),
    .ld_valid_i (ld_valid_i),
    .mode_o     (mode),
    .out_en_o   (out_en),
    .last_rnd_o (last_rnd),
    .busy_o     (busy_o),
    .ct_valid_o (ct_valid_o),
    .done_o     (done_o)
  );

  aes_ws_state u_state (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .mode_i     (mode),
    .out_en_i   (out_en),
    .last_rnd_i (last_rnd),
    .ld_word_i  (ld_text_i ^ ld_key_i),
    .rk_word_i  (rk_word_i),
    .head_o     (head)
  );

  assign ct_word_o = ct_valid_o ? head : '0;

  // R7
  valid_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    ct_valid_o |-> busy_o);

endmodule

// File: tb/aes_ws_core_tb.sv
module aes_ws_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  key_size_i = 2'b00;
  logic        ld_valid_i = 1'b0;
  logic [31:0] ld_text_i = '0;
  logic [31:0] ld_key_i = '0;
  logic [31:0] rk_word_i = '0;
  logic        busy_o, ct_valid_o, done_o;
  logic [31:0] ct_word_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  sb [0:255];
  logic [31:0] wk [0:59];

  always #5 clk = ~clk;

  aes_ws_core dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .key_size_i(key_size_i),
    .ld_valid_i(ld_valid_i), .ld_text_i(ld_text_i), .ld_key_i(ld_key_i),
    .rk_word_i(rk_word_i), .busy_o(busy_o), .ct_valid_o(ct_valid_o),
    .done_o(done_o), .ct_word_o(ct_word_o)
  );

  function automatic logic [7:0] m_xt(logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] m_mul(logic [7:0] a, logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] x;
    acc = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ x;
      x = m_xt(x);
    end
    return acc;
  endfunction

  task automatic build_sbox();
    logic [7:0] inv;
    logic [7:0] c;
    c = 8'h63;
    for (int x = 0; x < 256; x++) begin
      inv = 8'h00;
      for (int y = 1; y < 256; y++)
        if (m_mul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      for (int i = 0; i < 8; i++)
        sb[x][i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8] ^
                   inv[(i+7)%8] ^ c[i];
    end
  endtask

  function automatic logic [31:0] m_subw(logic [31:0] w);
    return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
  endfunction

  task automatic key_expand(input logic [255:0] key, input int nk, input int nr);
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < nk; i++) wk[i] = key[255-32*i -: 32];
    for (int i = nk; i < 4*(nr+1); i++) begin
      t = wk[i-1];
      if (i % nk == 0) begin
        t = m_subw({t[23:0], t[31:24]}) ^ {rc, 24'h0};
        rc = m_xt(rc);
      end else if (nk > 6 && i % nk == 4) begin
        t = m_subw(t);
      end
      wk[i] = wk[i-nk] ^ t;
    end
  endtask

  task automatic model_encrypt(input logic [127:0] pt, input int nr,
                               output logic [127:0] ct);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        s[4*c+r] = pt[127-8*(4*c+r) -: 8] ^ wk[c][31-8*r -: 8];
    for (int rnd = 1; rnd <= nr; rnd++) begin
      for (int i = 0; i < 16; i++) t[i] = sb[s[i]];
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++) s[4*c+r] = t[4*((c+r)%4)+r];
      if (rnd < nr) begin
        for (int c = 0; c < 4; c++) begin
          a0 = s[4*c]; a1 = s[4*c+1]; a2 = s[4*c+2]; a3 = s[4*c+3];
          s[4*c]   = m_mul(8'h02, a0) ^ m_mul(8'h03, a1) ^ a2 ^ a3;
          s[4*c+1] = a0 ^ m_mul(8'h02, a1) ^ m_mul(8'h03, a2) ^ a3;
          s[4*c+2] = a0 ^ a1 ^ m_mul(8'h02, a2) ^ m_mul(8'h03, a3);
          s[4*c+3] = m_mul(8'h03, a0) ^ a1 ^ a2 ^ m_mul(8'h02, a3);
        end
      end
      for (int c = 0; c < 4; c++)
        for (int r = 0; r < 4; r++)
          s[4*c+r] = s[4*c+r] ^ wk[4*rnd+c][31-8*r -: 8];
    end
    for (int i = 0; i < 16; i++) ct[127-8*i -: 8] = s[i];
  endtask

  task automatic chk(input string req, input logic eb, input logic ev,
                     input logic ed, input logic [31:0] ew);
    checks++;
    if ({busy_o, ct_valid_o, done_o, ct_word_o} !== {eb, ev, ed, ew}) begin
      fails++;
      $display("FAIL %s busy/valid/done/word actual %b%b%b %h expected %b%b%b %h",
               req, busy_o, ct_valid_o, done_o, ct_word_o, eb, ev, ed, ew);
    end
  endtask

  task automatic chk_val(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_block(input logic [127:0] pt, input logic [255:0] key,
                           input logic [1:0] ksz, input bit gaps, input bit noise,
                           input bit has_known, input logic [127:0] known,
                           input string rtag);
    int nk, nr, acc, j;
    logic [127:0] ct;
    nk = (ksz == 2'b00) ? 4 : (ksz == 2'b01) ? 6 : 8;
    nr = nk + 6;
    key_expand(key, nk, nr);
    model_encrypt(pt, nr, ct);
    if (has_known) chk_val("R5 model", ct, known);
    @(negedge clk);
    chk("R7 idle", 1'b0, 1'b0, 1'b0, 32'h0);
    start_i = 1'b1;
    key_size_i = ksz;
    acc = 0;
    j = 0;
    while (acc < 4) begin
      @(negedge clk);
      chk(noise ? "R8 load" : "R2 load", 1'b1, 1'b0, 1'b0, 32'h0);
      start_i = noise;
      key_size_i = noise ? ~ksz : ksz;
      if (gaps && (j % 3 == 1)) begin
        ld_valid_i = 1'b0;
        ld_text_i = 32'hdead_beef ^ 32'(j);
        ld_key_i = 32'h5a5a_0ff0;
      end else begin
        ld_valid_i = 1'b1;
        ld_text_i = pt[127-32*acc -: 32];
        ld_key_i = key[255-32*acc -: 32];
        acc++;
      end
      j++;
    end
    for (int k = 0; k < 4*nr; k++) begin
      @(negedge clk);
      chk(rtag, 1'b1, 1'b0, 1'b0, 32'h0);
      ld_valid_i = 1'b0;
      ld_text_i = 32'h1234_5678;
      rk_word_i = wk[4+k];
      start_i = noise && (k % 5 == 2);
    end
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R5 R6 out", 1'b1, 1'b1, (k == 3), ct[127-32*k -: 32]);
      rk_word_i = 32'hffff_0000 ^ 32'(k);
      start_i = noise;
    end
    @(negedge clk);
    chk("R7 R9 end", 1'b0, 1'b0, 1'b0, 32'h0);
    start_i = 1'b0;
    key_size_i = 2'b00;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    build_sbox();
    repeat (3) @(negedge clk);
    chk("R1 in reset", 1'b0, 1'b0, 1'b0, 32'h0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after reset", 1'b0, 1'b0, 1'b0, 32'h0);

    run_block(128'h00112233445566778899aabbccddeeff,
              {128'h000102030405060708090a0b0c0d0e0f, 128'h0}, 2'b00, 1'b0, 1'b0,
              1'b1, 128'h69c4e0d86a7b0430d8cdb78070b4c55a, "R4 rounds");
    run_block(128'h00112233445566778899aabbccddeeff,
              {192'h000102030405060708090a0b0c0d0e0f1011121314151617, 64'h0}, 2'b01,
              1'b1, 1'b1, 1'b1, 128'hdda97ca4864cdfe06eaf70a0ec0d7191, "R3 rounds");
    run_block(128'h00112233445566778899aabbccddeeff,
              256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
              2'b10, 1'b0, 1'b0, 1'b1, 128'h8ea2b7ca516745bfeafc49904b496089, "R4 rounds");
    run_block(128'h3243f6a8885a308d313198a2e0370734,
              {128'h2b7e151628aed2a6abf7158809cf4f3c, 128'h0}, 2'b00, 1'b1, 1'b1,
              1'b1, 128'h3925841d02dc09fbdc118597196a0b32, "R8 rounds");
    run_block(128'h00112233445566778899aabbccddeeff,
              256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f,
              2'b11, 1'b1, 1'b0, 1'b1, 128'h8ea2b7ca516745bfeafc49904b496089, "R3 rounds");
    run_block(128'hffeeddccbbaa99887766554433221100,
              {192'hc3a1_07f2_99d0_1e6b_44a5_2c7e_f0b3_8d16_5e29_ab40, 64'h0}, 2'b01,
              1'b1, 1'b0, 1'b0, 128'h0, "R4 rounds");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule